// File: doc/BRIEF.md
# Indexed CMOS Register Port

This block puts a 128-byte array of control registers and battery-style RAM behind a two-address byte port. The host first writes a 7-bit index to the even address. It then reads or writes the selected byte through the odd address. Four control registers sit at fixed indices (A at 0x0A, B at 0x0B, C at 0x0C, D at 0x0D). Each follows its own rules: some bits are read-only, two registers ignore writes, and reading the status register clears it. Every other index is ordinary storage.

The block does not count time itself. Separate timekeeping logic sees registers A and B on output pins. That logic raises and lowers the update-in-progress bit and ORs event flags into register C through sideband inputs. In return, this block pulses an output when software writes a time field while the clock is running. It pulses another output when software releases the SET bit, so the stored time fields can be reloaded. The interrupt line is bit 7 of register C.

Requests arrive as single-beat valid transfers and the port accepts one on every cycle. There is no ready signal. The read response has no back-pressure: `rsp_valid` is high for exactly one cycle, the cycle after the read request, and `rsp_rdata` is valid only while it is high.

Top module: `cmos_index_port`

## Requirements
- R1: A write to address 0 stores bits 6:0 of the data as the index (bit 7 is dropped). An address-1 access reads or writes the byte at that index. Indices other than 0x0A–0x0D read back what was last written.
- R2: A read at address 0 returns 0xFF. Every read answers with `rsp_valid` high for one cycle, one cycle after the request.
- R3: Bit 7 of register A (update in progress) ignores port writes: a write stores bits 6:0 and keeps bit 7.
- R4: A write to register B with bit 7 (SET) high clears bit 7 of register A. This has priority over `uip_set`.
- R5: A write to register B that changes bit 7 from 1 to 0 gives a one-cycle `time_reload` pulse in the following cycle.
- R6: A write to a time index (0x00, 0x02, 0x04, 0x06, 0x07, 0x08, 0x09) while B bit 7 is 0 gives a one-cycle `time_wr` pulse in the following cycle, with `time_wr_idx` equal to the index. There is no pulse while SET is 1, and none for indices 0x01, 0x03 or 0x05.
- R7: Registers C and D ignore port writes.
- R8: A read of register C returns its value and clears it to 0x00, so `irq` (C bit 7) is low in the next cycle. Flags on `evt_flags` in the same cycle are kept.
- R9: After `rst_n`, A=0x26, B=0x02, C=0x00, D=0x80, the index is 0 and `irq` is low.
- R10: `soft_rst` clears B bits 6, 5 and 3 and C bits 7 to 4, taking `irq` low. This takes effect after any write or flag in the same cycle.
- R11: `uip_set` sets A bit 7 and `uip_clr` clears it. `evt_flags` is ORed into register C each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| soft_rst | input | 1 | Synchronous reset of the enables and flags |
| req_valid | input | 1 | Request beat present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 1 | 0 = index address, 1 = data address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle) |
| rsp_rdata | output | 8 | Read data |
| uip_set | input | 1 | Timekeeping sets the update-in-progress bit |
| uip_clr | input | 1 | Timekeeping clears the update-in-progress bit |
| evt_flags | input | 8 | Flags ORed into register C |
| reg_a_o | output | 8 | Current register A |
| reg_b_o | output | 8 | Current register B |
| irq | output | 1 | Interrupt line, register C bit 7 |
| time_wr | output | 1 | A time field was written while running |
| time_wr_idx | output | 7 | Index of that field |
| time_reload | output | 1 | SET was released; reload the time fields |

## Verification
The bench writes an index with bit 7 set; a design that kept that bit would land on a different byte. It raises the update-in-progress bit from the sideband and then writes register A. A writable bit 7 would show 0 where the bench expects 1. It writes SET high and then low, watching for the reload pulse and for UIP being forced low; a missing pulse or a stale UIP bit is reported. Register C is read with a flag arriving in the same cycle. A design that let the clear win, or that ignored writes to C and D incorrectly, gives a wrong byte on the next read or a wrong `irq`.

// File: rtl/cmos_port_pkg.sv
package cmos_port_pkg;
  localparam int IDX_W  = 7;
  localparam int BYTE_W = 8;

  localparam logic [IDX_W-1:0] IDX_A = 7'h0A;
  localparam logic [IDX_W-1:0] IDX_B = 7'h0B;
  localparam logic [IDX_W-1:0] IDX_C = 7'h0C;
  localparam logic [IDX_W-1:0] IDX_D = 7'h0D;

  localparam logic [BYTE_W-1:0] A_INIT = 8'h26;
  localparam logic [BYTE_W-1:0] B_INIT = 8'h02;
  localparam logic [BYTE_W-1:0] C_INIT = 8'h00;
  localparam logic [BYTE_W-1:0] D_INIT = 8'h80;

  // soft reset masks: B keeps all but periodic/alarm/square-wave enables,
  // C keeps only its low nibble
  localparam logic [BYTE_W-1:0] B_SOFT_KEEP = 8'h97;
  localparam logic [BYTE_W-1:0] C_SOFT_KEEP = 8'h0F;

  typedef enum logic [2:0] {SEL_RAM, SEL_A, SEL_B, SEL_C, SEL_D} reg_sel_e;

  function automatic reg_sel_e decode_idx(input logic [IDX_W-1:0] idx);
    case (idx)
      IDX_A:   return SEL_A;
      IDX_B:   return SEL_B;
      IDX_C:   return SEL_C;
      IDX_D:   return SEL_D;
      default: return SEL_RAM;
    endcase
  endfunction

  function automatic logic is_time_idx(input logic [IDX_W-1:0] idx);
    return (idx == 7'h00) || (idx == 7'h02) || (idx == 7'h04) ||
           (idx == 7'h06) || (idx == 7'h07) || (idx == 7'h08) ||
           (idx == 7'h09);
  endfunction
endpackage

// File: rtl/cmos_ram.sv
module cmos_ram #(
  parameter int IDX_W  = 7,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/cmos_ctrl_regs.sv
module cmos_ctrl_regs
  import cmos_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wr_a,
  input  logic              wr_b,
  input  logic              rd_c,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              uip_set,
  input  logic              uip_clr,
  input  logic [BYTE_W-1:0] evt_flags,
  output logic [BYTE_W-1:0] reg_a,
  output logic [BYTE_W-1:0] reg_b,
  output logic [BYTE_W-1:0] reg_c,
  output logic [BYTE_W-1:0] reg_d,
  output logic              reload
);
  logic [BYTE_W-1:0] a_q, b_q, c_q;
  logic [BYTE_W-1:0] a_n, b_n, c_n;
  logic              uip_n;

  always_comb begin
    uip_n = a_q[7];
    if (uip_set) uip_n = 1'b1;
    if (uip_clr) uip_n = 1'b0;
    if (wr_b && wdata[7]) uip_n = 1'b0;
    a_n = {uip_n, (wr_a ? wdata[6:0] : a_q[6:0])};

    b_n = wr_b ? wdata : b_q;
    c_n = (rd_c ? '0 : c_q) | evt_flags;
    if (soft_rst) begin
      b_n = b_n & B_SOFT_KEEP;
      c_n = c_n & C_SOFT_KEEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= A_INIT;
      b_q    <= B_INIT;
      c_q    <= C_INIT;
      reload <= 1'b0;
    end else begin
      a_q    <= a_n;
      b_q    <= b_n;
      c_q    <= c_n;
      reload <= wr_b && b_q[7] && !wdata[7];
    end
  end

  assign reg_a = a_q;
  assign reg_b = b_q;
  assign reg_c = c_q;
  assign reg_d = D_INIT;
endmodule

// File: rtl/cmos_time_notify.sv
module cmos_time_notify
  import cmos_port_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_wr,
  input  logic [IDX_W-1:0] idx,
  input  logic             set_mode,
  output logic             time_wr,
  output logic [IDX_W-1:0] time_wr_idx
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_wr     <= 1'b0;
      time_wr_idx <= '0;
    end else begin
      time_wr <= data_wr && is_time_idx(idx) && !set_mode;
      if (data_wr) time_wr_idx <= idx;
    end
  end
endmodule

// File: rtl/cmos_index_port.sv
module cmos_index_port
  import cmos_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_addr,
  input  logic [BYTE_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [BYTE_W-1:0] rsp_rdata,
  input  logic              uip_set,
  input  logic              uip_clr,
  input  logic [BYTE_W-1:0] evt_flags,
  output logic [BYTE_W-1:0] reg_a_o,
  output logic [BYTE_W-1:0] reg_b_o,
  output logic              irq,
  output logic              time_wr,
  output logic [IDX_W-1:0]  time_wr_idx,
  output logic              time_reload
);
  logic [IDX_W-1:0]  idx_q;
  logic              data_wr, data_rd, idx_wr;
  reg_sel_e          sel;
  logic [BYTE_W-1:0] ram_rdata, reg_c, reg_d, sel_byte;

  assign idx_wr  = req_valid &&  req_write && !req_addr;
  assign data_wr = req_valid &&  req_write &&  req_addr;
  assign data_rd = req_valid && !req_write &&  req_addr;
  assign sel     = decode_idx(idx_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else if (idx_wr) idx_q <= req_wdata[IDX_W-1:0];
  end

  cmos_ram #(.IDX_W(IDX_W), .BYTE_W(BYTE_W)) u_ram (
    .clk   (clk),
    .we    (data_wr && (sel == SEL_RAM)),
    .addr  (idx_q),
    .wdata (req_wdata),
    .rdata (ram_rdata)
  );

  cmos_ctrl_regs u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .wr_a      (data_wr && (sel == SEL_A)),
    .wr_b      (data_wr && (sel == SEL_B)),
    .rd_c      (data_rd && (sel == SEL_C)),
    .wdata     (req_wdata),
    .uip_set   (uip_set),
    .uip_clr   (uip_clr),
    .evt_flags (evt_flags),
    .reg_a     (reg_a_o),
    .reg_b     (reg_b_o),
    .reg_c     (reg_c),
    .reg_d     (reg_d),
    .reload    (time_reload)
  );

  cmos_time_notify u_notify (
    .clk         (clk),
    .rst_n       (rst_n),
    .data_wr     (data_wr),
    .idx         (idx_q),
    .set_mode    (reg_b_o[7]),
    .time_wr     (time_wr),
    .time_wr_idx (time_wr_idx)
  );

  always_comb begin
    case (sel)
      SEL_A:   sel_byte = reg_a_o;
      SEL_B:   sel_byte = reg_b_o;
      SEL_C:   sel_byte = reg_c;
      SEL_D:   sel_byte = reg_d;
      default: sel_byte = ram_rdata;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      if (req_valid && !req_write)
        rsp_rdata <= req_addr ? sel_byte : 8'hFF;
    end
  end

  assign irq = reg_c[7];
endmodule

// File: rtl/cmos_index_port_sva.sv
module cmos_index_port_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       soft_rst,
  input logic       req_valid,
  input logic       req_write,
  input logic       req_addr,
  input logic [7:0] req_wdata,
  input logic [6:0] idx_q,
  input logic       uip_set,
  input logic       uip_clr,
  input logic [7:0] evt_flags,
  input logic [7:0] reg_a_o,
  input logic [7:0] reg_b_o,
  input logic       irq,
  input logic       rsp_valid,
  input logic [7:0] rsp_rdata,
  input logic       time_reload
);
  logic wr_odd, rd_odd;
  assign wr_odd = req_valid && req_write && req_addr;
  assign rd_odd = req_valid && !req_write && req_addr;

  a_r2_even_read_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !req_addr) |=> (rsp_valid && rsp_rdata == 8'hFF));

  a_r3_uip_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_odd && idx_q == 7'h0A && !uip_set && !uip_clr) |=> (reg_a_o[7] == $past(reg_a_o[7])));

  a_r4_set_clears_uip: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_odd && idx_q == 7'h0B && req_wdata[7]) |=> !reg_a_o[7]);

  a_r5_reload_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_odd && idx_q == 7'h0B && reg_b_o[7] && !req_wdata[7]) |=> time_reload);

  a_r8_read_c_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_odd && idx_q == 7'h0C && !evt_flags[7]) |=> !irq);

  a_r10_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!irq && reg_b_o[6:5] == 2'b00 && !reg_b_o[3]));
endmodule

bind cmos_index_port cmos_index_port_sva u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .soft_rst    (soft_rst),
  .req_valid   (req_valid),
  .req_write   (req_write),
  .req_addr    (req_addr),
  .req_wdata   (req_wdata),
  .idx_q       (idx_q),
  .uip_set     (uip_set),
  .uip_clr     (uip_clr),
  .evt_flags   (evt_flags),
  .reg_a_o     (reg_a_o),
  .reg_b_o     (reg_b_o),
  .irq         (irq),
  .rsp_valid   (rsp_valid),
  .rsp_rdata   (rsp_rdata),
  .time_reload (time_reload)
);

// File: tb/cmos_index_port_bench.sv
module cmos_index_port_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_addr = 1'b0;
  logic [7:0] req_wdata = 8'h00;
  logic uip_set = 1'b0, uip_clr = 1'b0;
  logic [7:0] evt_flags = 8'h00;
  logic rsp_valid, irq, time_wr, time_reload;
  logic [7:0] rsp_rdata, reg_a_o, reg_b_o;
  logic [6:0] time_wr_idx;

  always #5 clk = ~clk;

  cmos_index_port u_cmos_index_port (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .uip_set(uip_set), .uip_clr(uip_clr), .evt_flags(evt_flags),
    .reg_a_o(reg_a_o), .reg_b_o(reg_b_o), .irq(irq),
    .time_wr(time_wr), .time_wr_idx(time_wr_idx), .time_reload(time_reload)
  );

  int vectors = 0;
  int misses = 0;
  string cur_req = "R9";

  // reference model state
  int m_mem [128];
  int m_idx, m_a, m_b, m_c;
  bit m_rsp_v, m_twr, m_reload;
  int m_rdata, m_twr_idx;

  function automatic bit time_field(int i);
    return i == 0 || i == 2 || i == 4 || i == 6 || i == 7 || i == 8 || i == 9;
  endfunction

  function automatic int peek(int i);
    if (i == 10) return m_a;
    if (i == 11) return m_b;
    if (i == 12) return m_c;
    if (i == 13) return 8'h80;
    return m_mem[i];
  endfunction

  task automatic model_reset();
    m_idx = 0; m_a = 8'h26; m_b = 8'h02; m_c = 0;
    m_rsp_v = 0; m_twr = 0; m_reload = 0; m_rdata = 0; m_twr_idx = 0;
  endtask

  task automatic model_step();
    bit rd = req_valid && !req_write;
    bit wr = req_valid && req_write;
    int d = req_wdata;
    int old_b = m_b;
    int nc;
    m_rsp_v = rd;
    if (rd) m_rdata = req_addr ? peek(m_idx) : 8'hFF;
    m_twr = wr && req_addr && time_field(m_idx) && !old_b[7];
    if (wr && req_addr) m_twr_idx = m_idx;
    m_reload = wr && req_addr && m_idx == 11 && old_b[7] && !d[7];
    if (uip_set) m_a = m_a | 8'h80;
    if (uip_clr) m_a = m_a & 8'h7F;
    nc = m_c;
    if (rd && req_addr && m_idx == 12) nc = 0;
    nc = nc | evt_flags;
    if (wr && req_addr) begin
      if (m_idx == 10) m_a = (m_a & 8'h80) | (d & 8'h7F);
      else if (m_idx == 11) begin
        m_b = d;
        if (d[7]) m_a = m_a & 8'h7F;
      end else if (m_idx != 12 && m_idx != 13) m_mem[m_idx] = d;
    end
    if (soft_rst) begin
      m_b = m_b & ~8'h68;
      nc = nc & 8'h0F;
    end
    m_c = nc;
    if (wr && !req_addr) m_idx = d & 8'h7F;
  endtask

  task automatic check(string what, int got, int exp);
    vectors++;
    if (got != exp) begin
      misses++;
      $display("FAIL %s %s got=%0h exp=%0h", cur_req, what, got, exp);
    end
  endtask

  task automatic compare();
    check("rsp_valid", rsp_valid, m_rsp_v);
    if (m_rsp_v) check("rsp_rdata", rsp_rdata, m_rdata);
    check("reg_a", reg_a_o, m_a);
    check("reg_b", reg_b_o, m_b);
    check("irq", irq, m_c >> 7);
    check("time_wr", time_wr, m_twr);
    if (m_twr) check("time_wr_idx", time_wr_idx, m_twr_idx);
    check("time_reload", time_reload, m_reload);
  endtask

  task automatic step();
    @(posedge clk);
    #1 model_step();
    @(negedge clk);
    compare();
    req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
    uip_set = 0; uip_clr = 0; evt_flags = 0; soft_rst = 0;
  endtask

  task automatic set_idx(int i);
    req_valid = 1; req_write = 1; req_addr = 0; req_wdata = 8'(i); step();
  endtask
  task automatic put(int d);
    req_valid = 1; req_write = 1; req_addr = 1; req_wdata = 8'(d); step();
  endtask
  task automatic get();
    req_valid = 1; req_write = 0; req_addr = 1; step(); step();
  endtask
  task automatic get_even();
    req_valid = 1; req_write = 0; req_addr = 0; step(); step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    misses++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) m_mem[i] = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9 power-up values, read C and D through the port
    cur_req = "R9";
    step();
    set_idx(8'h0C); get();
    set_idx(8'h0D); get();
    set_idx(8'h0A); get();
    // R1 index latching drops bit 7, plain RAM bytes
    cur_req = "R1";
    set_idx(8'h8F); put(8'h5A);
    set_idx(8'h0F); get();
    set_idx(8'h70); put(8'hC3);
    set_idx(8'h20); put(8'h11);
    set_idx(8'hF0); get();
    set_idx(8'hA0); get();
    // R2 even address read
    cur_req = "R2";
    get_even();
    // R11 / R3 UIP from sideband, then read-only on write
    cur_req = "R11";
    uip_set = 1; step();
    cur_req = "R3";
    set_idx(8'h0A); put(8'h00); get();
    put(8'h2F); get();
    // R4 SET write clears UIP even with uip_set in the same cycle
    cur_req = "R4";
    set_idx(8'h0B); uip_set = 1; put(8'h82);
    // R6 no pulse while SET
    cur_req = "R6";
    set_idx(8'h00); put(8'h30);
    // R5 SET release
    cur_req = "R5";
    set_idx(8'h0B); put(8'h02); step();
    // R6 time and alarm writes while running
    cur_req = "R6";
    set_idx(8'h02); put(8'h45);
    set_idx(8'h09); put(8'h99);
    set_idx(8'h03); put(8'h12);
    set_idx(8'h02); get();
    // R7 C and D ignore writes
    cur_req = "R7";
    set_idx(8'h0C); put(8'hFF); get();
    set_idx(8'h0D); put(8'h00); get();
    // R8 clear on read, flag in same cycle survives
    cur_req = "R8";
    evt_flags = 8'hD0; step();
    set_idx(8'h0C); get();
    evt_flags = 8'h90; req_valid = 1; req_write = 0; req_addr = 1; step(); step();
    get(); get();
    // R11 uip_clr
    cur_req = "R11";
    uip_set = 1; step(); uip_clr = 1; step();
    // R10 soft reset
    cur_req = "R10";
    set_idx(8'h0B); put(8'h7A);
    evt_flags = 8'hF5; step();
    soft_rst = 1; step();
    get(); set_idx(8'h0C); get();
    repeat (2) step();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule